// File: doc/BRIEF.md
# Dual-role SPI serial controller

The block is one SPI engine for a four-wire, full-duplex bus (serial clock, master-out data, master-in data and an active-low select). Software chooses whether it drives the bus as master or answers as a slave. As master it makes the serial clock from the system clock through an 8-bit divider. As slave it runs every external line through a synchronizer clocked by the system clock, and it finds serial clock edges by comparing successive synchronized samples. Frames carry from one to eight bits. The most significant bit of the frame goes first.

Software sees four byte-wide registers through a simple write/read strobe interface. The register at address 0 holds clock polarity in bit 0, clock phase in bit 1 and the frame length code in bits 4:2. The register at address 1 holds control and status: enable in bit 0, master role in bit 1, frame-done in bit 2, write-collision in bit 3, mode-fault in bit 4, receive-overrun in bit 5 and busy in bit 6, which is read-only. The clock divider sits at address 2. The data register sits at address 3. Writing it supplies transmit data and, in master mode, starts a frame. Reading it returns the receive buffer. Several masters may share the bus. If the select input goes low while this block is master, it records a mode fault, leaves the master role and releases its drivers.

Top module: `spi_duplex_ctrl`

## Requirements
- R1: After reset every register reads zero, the interrupt is low and none of the three output enables is asserted.
- R2: In master mode a data write starts a frame of 2·N serial clock edges, each half period lasting divider+1 system clocks. Busy stays high for exactly 2·N·(divider+1) cycles after the write. The serial clock rests at the polarity bit whenever no frame is running.
- R3: A frame holds N = length code + 1 bits. Bits go out starting at bit N-1 of the written byte and ending at bit 0. The received byte holds the N incoming bits in its low N positions, first bit highest, with every bit above them zero.
- R4: With clock phase 0 input data is sampled on the leading (first) clock edge of each bit and output changes on the trailing edge. With clock phase 1 output changes on the leading edge and input is sampled on the trailing edge.
- R5: In slave mode with the select low, the block exchanges an N-bit frame with an external master at a serial clock of one tenth of the system clock, in all four polarity/phase combinations.
- R6: In slave mode with the select high, serial clock activity receives no data, sets no flag and leaves the input-data output enable low.
- R7: A data write during a frame in progress sets the write-collision flag and leaves the frame's transmitted data unchanged.
- R8: At the end of each frame the received value moves to the receive buffer and the frame-done flag (address 1, bit 2) sets.
- R9: If a frame completes while the previous received value has not been read through the data register, the receive-overrun flag (address 1, bit 5) sets.
- R10: Select driven low while the block is enabled as master sets mode-fault (address 1, bit 4), clears the master bit, ends any frame and drops the clock and data output enables.
- R11: The interrupt is high while any of frame-done, write-collision, mode-fault or overrun is set. Writing 0 to a flag bit clears it and writing 1 leaves it as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (marks the receive buffer as read) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| irq | output | 1 | Interrupt request |
| sck_i | input | 1 | Serial clock from the bus (slave mode) |
| sck_o | output | 1 | Serial clock driven in master mode |
| sck_oe | output | 1 | Serial clock output enable |
| mosi_i | input | 1 | Master-out data from the bus (slave mode) |
| mosi_o | output | 1 | Master-out data driven in master mode |
| mosi_oe | output | 1 | Master-out data output enable |
| miso_i | input | 1 | Master-in data from the bus (master mode) |
| miso_o | output | 1 | Master-in data driven in slave mode |
| miso_oe | output | 1 | Master-in data output enable |
| nss_i | input | 1 | Active-low select input |

## Verification
The hardest case to reach from the ports is a select collision that lands in the middle of a master frame. It is the only way to find out whether the abort leaves busy, the clock phase and the output enables in a clean state. The bench starts a frame with a large divider so that the frame lasts hundreds of cycles, then pulls the select low after a few clock edges. It then confirms the fault flag, the cleared master bit and the released drivers, and checks that a later write to the control register brings the master role back with the fault cleared. Slave frames use a second hard-to-reach setup. The bench acts as an external master that moves its data line on launch edges only, spaced slowly enough to get through the synchronizer delay. This tests each of the four phase/polarity combinations against the select-time preload of the first output bit.

// File: rtl/spi_duplex_ctrl.sv
module spi_duplex_ctrl #(
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] reg_addr,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  input  logic       sck_i,
  output logic       sck_o,
  output logic       sck_oe,
  input  logic       mosi_i,
  output logic       mosi_o,
  output logic       mosi_oe,
  input  logic       miso_i,
  output logic       miso_o,
  output logic       miso_oe,
  input  logic       nss_i
);
  localparam logic [1:0] A_CFG = 2'd0, A_CTL = 2'd1, A_DIV = 2'd2, A_DAT = 2'd3;

  logic             cpol, cpha;
  logic [2:0]       len_q;
  logic             en, mst, busy;
  logic             f_done, f_wcol, f_modf, f_ovr;
  logic [DIV_W-1:0] div_q, hcnt;
  logic [7:0]       sh, rxbuf;
  logic             rx_full;
  logic [4:0]       ecnt;
  logic             ph, obit;
  logic [SYNC_STAGES-1:0] sck_sy, nss_sy, mosi_sy;
  logic             sck_prev, sel_q;

  wire [3:0] nbits     = {1'b0, len_q} + 4'd1;
  wire [4:0] last_edge = {nbits, 1'b0};
  wire [7:0] mask      = 8'hFF >> (4'd8 - nbits);

  wire sck_s  = sck_sy[SYNC_STAGES-1];
  wire nss_s  = nss_sy[SYNC_STAGES-1];
  wire mosi_s = mosi_sy[SYNC_STAGES-1];

  wire wr_cfg = reg_wr & (reg_addr == A_CFG);
  wire wr_ctl = reg_wr & (reg_addr == A_CTL);
  wire wr_div = reg_wr & (reg_addr == A_DIV);
  wire wr_dat = reg_wr & (reg_addr == A_DAT);
  wire rd_dat = reg_rd & (reg_addr == A_DAT);

  wire m_on    = en & mst;
  wire s_sel   = en & ~mst & ~nss_s;
  wire modf_ev = m_on & ~nss_s;
  wire en_d    = wr_ctl ? reg_wdata[0] : en;
  wire mst_d   = modf_ev ? 1'b0 : (wr_ctl ? reg_wdata[1] : mst);
  wire m_keep  = en_d & mst_d;

  wire m_tick    = busy & (hcnt == div_q);
  wire s_tog     = s_sel & sel_q & (sck_s != sck_prev);
  wire edge_ev   = m_tick | s_tog;
  wire lead      = ~ecnt[0];
  wire samp_ev   = edge_ev & (lead ^ cpha);
  wire launch_ev = edge_ev & ~(lead ^ cpha);
  wire in_bit    = m_on ? miso_i : mosi_s;
  wire [7:0] sh_d = samp_ev ? {sh[6:0], in_bit} : sh;
  wire fin       = edge_ev & ((ecnt + 5'd1) == last_edge);

  wire s_busy  = s_sel & (ecnt != 5'd0);
  wire m_start = wr_dat & m_on & ~busy & m_keep;
  wire s_load  = wr_dat & ~m_on & ~s_busy;
  wire wcol_ev = wr_dat & ((m_on & busy) | s_busy);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_sy   <= '0;
      nss_sy   <= '1;
      mosi_sy  <= '0;
      sck_prev <= 1'b0;
      sel_q    <= 1'b0;
    end else begin
      sck_sy   <= {sck_sy[SYNC_STAGES-2:0], sck_i};
      nss_sy   <= {nss_sy[SYNC_STAGES-2:0], nss_i};
      mosi_sy  <= {mosi_sy[SYNC_STAGES-2:0], mosi_i};
      sck_prev <= sck_s;
      sel_q    <= s_sel;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cpol  <= 1'b0;
      cpha  <= 1'b0;
      len_q <= 3'd0;
      div_q <= '0;
      en    <= 1'b0;
      mst   <= 1'b0;
    end else begin
      if (wr_cfg) begin
        cpol  <= reg_wdata[0];
        cpha  <= reg_wdata[1];
        len_q <= reg_wdata[4:2];
      end
      if (wr_div) div_q <= reg_wdata[DIV_W-1:0];
      en  <= en_d;
      mst <= mst_d;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy <= 1'b0;
      hcnt <= '0;
      ph   <= 1'b0;
    end else begin
      if (!m_keep)         busy <= 1'b0;
      else if (m_start)    busy <= 1'b1;
      else if (fin & busy) busy <= 1'b0;

      if (m_start)   hcnt <= '0;
      else if (busy) hcnt <= m_tick ? '0 : hcnt + 1'b1;

      if (!m_keep || m_start) ph <= 1'b0;
      else if (m_tick)        ph <= ~ph;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sh   <= 8'h00;
      obit <= 1'b0;
      ecnt <= 5'd0;
    end else if (m_start) begin
      sh   <= reg_wdata;
      obit <= reg_wdata[len_q];
      ecnt <= 5'd0;
    end else if (s_load) begin
      sh   <= reg_wdata;
      obit <= reg_wdata[len_q];
    end else begin
      sh <= sh_d;
      if (s_sel & ~sel_q) begin
        ecnt <= 5'd0;
        obit <= sh[len_q];
      end else begin
        if (launch_ev) obit <= sh[len_q];
        if (edge_ev)   ecnt <= fin ? 5'd0 : ecnt + 5'd1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rxbuf   <= 8'h00;
      rx_full <= 1'b0;
      f_done  <= 1'b0;
      f_wcol  <= 1'b0;
      f_modf  <= 1'b0;
      f_ovr   <= 1'b0;
    end else begin
      if (fin) rxbuf <= sh_d & mask;

      if (fin)         rx_full <= 1'b1;
      else if (rd_dat) rx_full <= 1'b0;

      if (fin)         f_done <= 1'b1;
      else if (wr_ctl) f_done <= f_done & reg_wdata[2];

      if (wcol_ev)     f_wcol <= 1'b1;
      else if (wr_ctl) f_wcol <= f_wcol & reg_wdata[3];

      if (modf_ev)     f_modf <= 1'b1;
      else if (wr_ctl) f_modf <= f_modf & reg_wdata[4];

      if (fin & rx_full & ~rd_dat) f_ovr <= 1'b1;
      else if (wr_ctl)             f_ovr <= f_ovr & reg_wdata[5];
    end

  always_comb
    case (reg_addr)
      A_CFG:   reg_rdata = {3'b000, len_q, cpha, cpol};
      A_CTL:   reg_rdata = {1'b0, busy, f_ovr, f_modf, f_wcol, f_done, mst, en};
      A_DIV:   reg_rdata = 8'(div_q);
      default: reg_rdata = rxbuf;
    endcase

  assign irq     = f_done | f_wcol | f_modf | f_ovr;
  assign sck_o   = m_on ? (cpol ^ ph) : cpol;
  assign sck_oe  = m_on;
  assign mosi_o  = obit;
  assign mosi_oe = m_on;
  assign miso_o  = obit;
  assign miso_oe = s_sel;

  p_busy_master_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (en && mst));

  p_idle_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mst && !busy) |-> (sck_o == cpol));

  p_wcol_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dat && en && mst && busy) |=> f_wcol);

  p_done_on_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> (f_done && rx_full));

  p_modf_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mst && !nss_s) |=> (f_modf && !mst && !busy && !sck_oe));
endmodule

// File: tb/sim_spi_duplex_ctrl.sv
module sim_spi_duplex_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = 8'h00, reg_rdata;
  logic irq, sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe, miso_i;
  logic sck_i = 1'b0, mosi_i = 1'b0, nss_i = 1'b1;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;
  assign miso_i = mosi_o;

  spi_duplex_ctrl u0 (.clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe), .mosi_i(mosi_i), .mosi_o(mosi_o),
    .mosi_oe(mosi_oe), .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe), .nss_i(nss_i));

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  function automatic logic [7:0] mk(input int nb);
    return 8'((1 << nb) - 1);
  endfunction

  task automatic mxfer(input int pol, input int cph, input int nb, input int dv, input logic [7:0] d);
    logic [7:0] m, got, v;
    logic prev;
    int c, tg;
    m = mk(nb);
    wr(2'd0, 8'(pol | (cph << 1) | ((nb - 1) << 2)));
    wr(2'd2, 8'(dv));
    #1 chk(sck_o == pol[0], "R2 idle clock level", sck_o, pol);
    wr(2'd3, d);
    reg_addr = 2'd1;
    got = 8'h00; c = 0; tg = 0; prev = sck_o;
    do begin
      @(negedge clk); #1;
      c++;
      if (sck_o !== prev) begin
        tg++;
        prev = sck_o;
        if ((tg % 2 == 1) != (cph == 1)) got = {got[6:0], mosi_o};
      end
    end while (reg_rdata[6] && c < 10000);
    chk(c == 2 * nb * (dv + 1), "R2 busy length", c, 2 * nb * (dv + 1));
    chk(tg == 2 * nb, "R2 edge count", tg, 2 * nb);
    chk(sck_o == pol[0], "R2 clock rests at polarity", sck_o, pol);
    chk((got & m) == (d & m), "R3 output bit order", got & m, d & m);
    peek(2'd1, v);
    chk(v[2] == 1'b1, "R8 done flag", v[2], 1);
    rd(2'd3, v);
    chk(v == (d & m), "R4 loopback sample phase", v, d & m);
    wr(2'd1, 8'h03);
  endtask

  task automatic sxfer(input int pol, input int cph, input int nb, input logic [7:0] mtx, input logic [7:0] stx);
    logic [7:0] m, rxb, v;
    m = mk(nb);
    wr(2'd1, 8'h01);
    wr(2'd0, 8'(pol | (cph << 1) | ((nb - 1) << 2)));
    sck_i = pol[0];
    wr(2'd3, stx);
    nss_i = 1'b0;
    repeat (8) @(negedge clk);
    if (cph == 0) mosi_i = mtx[nb - 1];
    rxb = 8'h00;
    for (int e = 1; e <= 2 * nb; e++) begin
      bit samp;
      int idx;
      samp = ((e % 2) == 1) != (cph == 1);
      repeat (5) @(negedge clk);
      if (samp) rxb = {rxb[6:0], miso_o};
      sck_i = ~sck_i;
      if (!samp) begin
        idx = (cph == 1) ? nb - (e + 1) / 2 : nb - 1 - e / 2;
        if (idx >= 0) mosi_i = mtx[idx];
      end
    end
    repeat (8) @(negedge clk);
    peek(2'd1, v);
    chk(v[2] == 1'b1, "R8 slave done flag", v[2], 1);
    rd(2'd3, v);
    chk(v == (mtx & m), "R5 slave receive", v, mtx & m);
    chk((rxb & m) == (stx & m), "R5 slave transmit", rxb & m, stx & m);
    nss_i = 1'b1;
    wr(2'd1, 8'h01);
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int a = 0; a < 4; a++) begin
      peek(2'(a), v);
      chk(v == 8'h00, "R1 register reset value", v, 0);
    end
    chk(!irq && !sck_oe && !mosi_oe && !miso_oe, "R1 outputs idle", {irq, sck_oe, mosi_oe, miso_oe}, 0);

    wr(2'd1, 8'h03);
    for (int pol = 0; pol < 2; pol++)
      for (int cph = 0; cph < 2; cph++)
        for (int nb = 1; nb <= 8; nb++)
          for (int k = 0; k < 2; k++) begin
            mxfer(pol, cph, nb, 2 * k, 8'h5A ^ 8'(nb * 37 + k * 113));
            mxfer(pol, cph, nb, 2 * k + 1, 8'hC3 ^ 8'(nb * 11 + k * 71));
          end

    // R7: write during frame
    wr(2'd0, 8'h1C); wr(2'd2, 8'd3);
    wr(2'd3, 8'hC3);
    repeat (3) @(negedge clk);
    wr(2'd3, 8'h3C);
    repeat (80) @(negedge clk);
    peek(2'd1, v);
    chk(v[3] == 1'b1, "R7 collision flag", v[3], 1);
    chk(irq == 1'b1, "R11 irq from flags", irq, 1);
    rd(2'd3, v);
    chk(v == 8'hC3, "R7 frame data kept", v, 8'hC3);
    wr(2'd1, 8'h0B);
    peek(2'd1, v);
    chk(v[3] == 1'b1 && v[2] == 1'b0, "R11 write 1 keeps, 0 clears", v, 8'h0B);
    chk(irq == 1'b1, "R11 irq held by remaining flag", irq, 1);
    wr(2'd1, 8'h03);
    #1 chk(irq == 1'b0, "R11 irq low when flags clear", irq, 0);

    // R9: overrun
    wr(2'd2, 8'd0);
    wr(2'd3, 8'h11);
    repeat (40) @(negedge clk);
    peek(2'd1, v);
    chk(v[5] == 1'b0, "R9 no overrun after first frame", v[5], 0);
    wr(2'd3, 8'h22);
    repeat (40) @(negedge clk);
    peek(2'd1, v);
    chk(v[5] == 1'b1, "R9 overrun flag", v[5], 1);
    peek(2'd3, v);
    chk(v == 8'h22, "R9 newest value in buffer", v, 8'h22);
    rd(2'd3, v);
    wr(2'd1, 8'h03);

    // R10: collision on select mid-frame
    wr(2'd2, 8'd20);
    wr(2'd3, 8'hF0);
    repeat (50) @(negedge clk);
    nss_i = 1'b0;
    repeat (6) @(negedge clk);
    peek(2'd1, v);
    chk(v[4] == 1'b1 && v[1] == 1'b0 && v[6] == 1'b0, "R10 fault ends master role", v, 8'h11);
    chk(!sck_oe && !mosi_oe, "R10 drivers released", {sck_oe, mosi_oe}, 0);
    chk(irq == 1'b1, "R11 irq on fault", irq, 1);
    nss_i = 1'b1;
    repeat (4) @(negedge clk);
    wr(2'd1, 8'h03);
    peek(2'd1, v);
    chk(v == 8'h03 && !irq, "R11 fault cleared and master restored", v, 8'h03);

    // R5 slave sweep
    for (int pol = 0; pol < 2; pol++)
      for (int cph = 0; cph < 2; cph++)
        for (int j = 0; j < 3; j++) begin
          sxfer(pol, cph, (j == 0) ? 1 : (j == 1) ? 5 : 8, 8'hB4 ^ 8'(j * 29), 8'h69 ^ 8'(j * 53 + pol * 7));
        end

    // R6: deselected slave ignores clock
    wr(2'd0, 8'h1C);
    peek(2'd3, v);
    for (int t = 0; t < 16; t++) begin
      repeat (5) @(negedge clk);
      sck_i = ~sck_i;
      mosi_i = t[0];
    end
    repeat (8) @(negedge clk);
    begin
      logic [7:0] c;
      peek(2'd1, c);
      chk(c[5:2] == 4'h0, "R6 no flags while deselected", c[5:2], 0);
      chk(miso_oe == 1'b0, "R6 data output not enabled", miso_oe, 0);
      peek(2'd3, c);
      chk(c == v, "R6 buffer untouched", c, v);
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R2 watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule